// File: doc/BRIEF.md
# Calendar Display Page Selector

This block sits between a BCD calendar and clock core and a digit display that has only eight digit positions. The display is too narrow to show the date and the time together, so the block shows one of two pages at a time. The date page carries the four-digit year, the month and the day. The time page carries hours, minutes and seconds, and its two spare positions are blank.

The page changes on a dwell timer that counts the core's one-second enable. Each page stays on the display for a fixed number of ticks, eight by default, and then the other page takes over. The two pages keep alternating for as long as ticks arrive.

The digit lanes are a pure selection of the current input digits. A change in any calendar digit therefore shows up on the lanes in the same cycle. The scanning multiplexer and the seven-segment decoder that follow this block are not part of it.

Top module: `cal_page_sel`

## Requirements
- R1: While `rst_n` is low, and right after it is released, the time page is shown (`page_is_date` = 0) and the dwell count is zero.
- R2: The dwell count advances only in a cycle where `sec_tick` is high. Cycles without a tick leave the page and the count unchanged, however many there are.
- R3: The page toggles on the rising clock edge that samples the DWELL_TICKS-th tick (8 by default) since reset or since the last toggle, and never on any other edge.
- R4: On the date page, `disp_digits` lanes from bits [31:28] down to [3:0] carry, in this order: year thousands, hundreds, tens, units, month tens, month units, day tens, day units.
- R5: On the time page, bits [31:28] down to [11:8] carry hour tens, hour units, minute tens, minute units, second tens, second units. Bits [7:0] hold the blank code 4'hF in both lanes.
- R6: `page_is_date` is 0 on the time page and 1 on the date page, and it changes on the same edge as the lanes.
- R7: Pulling `rst_n` low in the middle of a dwell returns the block to the time page with the count cleared, so after release a full DWELL_TICKS ticks pass before the next toggle.
- R8: Alternation continues without end: 2*DWELL_TICKS ticks after a toggle to the date page, the date page is shown again.
- R9: On the current page, a change of an input digit appears on the lanes in the same cycle, with no clock edge needed.
- R10: Ticks count the same whether they arrive back to back or with idle cycles between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous clear |
| sec_tick | input | 1 | One-cycle one-second enable |
| yr_thou | input | 4 | Year thousands digit (BCD) |
| yr_hund | input | 4 | Year hundreds digit |
| yr_tens | input | 4 | Year tens digit |
| yr_unit | input | 4 | Year units digit |
| mon_tens | input | 4 | Month tens digit |
| mon_unit | input | 4 | Month units digit |
| day_tens | input | 4 | Day tens digit |
| day_unit | input | 4 | Day units digit |
| hr_tens | input | 4 | Hour tens digit |
| hr_unit | input | 4 | Hour units digit |
| min_tens | input | 4 | Minute tens digit |
| min_unit | input | 4 | Minute units digit |
| sec_tens | input | 4 | Second tens digit |
| sec_unit | input | 4 | Second units digit |
| disp_digits | output | 32 | Eight BCD lanes; lane 0 (leftmost) at [31:28] |
| page_is_date | output | 1 | 0 for the time page, 1 for the date page |

## Verification
A dwell count that is off by one makes a page change one tick early or one tick late. The first toggle after reset then lands on the wrong edge, within DWELL_TICKS ticks. A page register that toggles without a tick changes `page_is_date` and every lane at the very next edge, even though the clock core has sent nothing. A swapped or mis-sliced lane shows up right away as a wrong digit position on the current page. On the time page it can also show as a non-blank value in the bottom two lanes.

// File: rtl/cal_page_pkg.sv
package cal_page_pkg;

  localparam int DIGIT_W     = 4;
  localparam int LANES       = 8;
  localparam int DATE_DIGITS = 8;
  localparam int TIME_DIGITS = 6;
  localparam logic [DIGIT_W-1:0] BLANK_DIGIT = 4'hF;

  typedef enum logic {
    PAGE_TIME = 1'b0,
    PAGE_DATE = 1'b1
  } page_e;

  function automatic page_e page_flip(input page_e p);
    return (p == PAGE_TIME) ? PAGE_DATE : PAGE_TIME;
  endfunction

  // Bit offset of lane k inside the packed display word; lane 0 is leftmost.
  function automatic int lane_lsb(input int k, input int n_lanes);
    return (n_lanes - 1 - k) * DIGIT_W;
  endfunction

endpackage

// File: rtl/dwell_timer.sv
module dwell_timer
  import cal_page_pkg::*;
#(
  parameter int DWELL_TICKS = 8,
  localparam int CNT_W = (DWELL_TICKS > 2) ? $clog2(DWELL_TICKS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap_evt,
  output page_e            page
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(DWELL_TICKS - 1);

  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c);
    return (c == LAST) ? '0 : c + 1'b1;
  endfunction

  assign wrap_evt = tick && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      page <= PAGE_TIME;
    end else begin
      if (tick)     cnt  <= cnt_next(cnt);
      if (wrap_evt) page <= page_flip(page);
    end
  end

endmodule

// File: rtl/page_mux.sv
module page_mux
  import cal_page_pkg::*;
(
  input  page_e                        page,
  input  logic [DATE_DIGITS*DIGIT_W-1:0] date_word,
  input  logic [TIME_DIGITS*DIGIT_W-1:0] time_word,
  output logic [LANES*DIGIT_W-1:0]       lanes
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [DIGIT_W-1:0] d_lane;
    logic [DIGIT_W-1:0] t_lane;
    if (k < DATE_DIGITS) begin : g_d
      assign d_lane = date_word[lane_lsb(k, DATE_DIGITS) +: DIGIT_W];
    end else begin : g_dblank
      assign d_lane = BLANK_DIGIT;
    end
    if (k < TIME_DIGITS) begin : g_t
      assign t_lane = time_word[lane_lsb(k, TIME_DIGITS) +: DIGIT_W];
    end else begin : g_tblank
      assign t_lane = BLANK_DIGIT;
    end
    assign lanes[lane_lsb(k, LANES) +: DIGIT_W] = (page == PAGE_DATE) ? d_lane : t_lane;
  end

endmodule

// File: rtl/cal_page_sel.sv
module cal_page_sel
  import cal_page_pkg::*;
#(
  parameter int DWELL_TICKS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_tick,
  input  logic [3:0]  yr_thou,
  input  logic [3:0]  yr_hund,
  input  logic [3:0]  yr_tens,
  input  logic [3:0]  yr_unit,
  input  logic [3:0]  mon_tens,
  input  logic [3:0]  mon_unit,
  input  logic [3:0]  day_tens,
  input  logic [3:0]  day_unit,
  input  logic [3:0]  hr_tens,
  input  logic [3:0]  hr_unit,
  input  logic [3:0]  min_tens,
  input  logic [3:0]  min_unit,
  input  logic [3:0]  sec_tens,
  input  logic [3:0]  sec_unit,
  output logic [31:0] disp_digits,
  output logic        page_is_date
);

  localparam int CNT_W = (DWELL_TICKS > 2) ? $clog2(DWELL_TICKS) : 1;

  logic [CNT_W-1:0] dwell_cnt;
  logic             wrap_evt;
  page_e            cur_page;

  logic [DATE_DIGITS*DIGIT_W-1:0] date_word;
  logic [TIME_DIGITS*DIGIT_W-1:0] time_word;

  assign date_word = {yr_thou, yr_hund, yr_tens, yr_unit,
                      mon_tens, mon_unit, day_tens, day_unit};
  assign time_word = {hr_tens, hr_unit, min_tens, min_unit, sec_tens, sec_unit};

  dwell_timer #(.DWELL_TICKS(DWELL_TICKS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (sec_tick),
    .cnt      (dwell_cnt),
    .wrap_evt (wrap_evt),
    .page     (cur_page)
  );

  page_mux u_mux (
    .page      (cur_page),
    .date_word (date_word),
    .time_word (time_word),
    .lanes     (disp_digits)
  );

  assign page_is_date = (cur_page == PAGE_DATE);

endmodule

// File: rtl/cal_page_sel_chk.sv
module cal_page_sel_chk #(
  parameter int DWELL_TICKS = 8,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sec_tick,
  input logic             page_is_date,
  input logic [31:0]      disp_digits,
  input logic [CNT_W-1:0] dwell_cnt,
  input logic             wrap_evt,
  input logic [3:0]       yr_thou,
  input logic [3:0]       hr_tens
);

  // Independent tick tally since the last page change.
  logic [CNT_W-1:0] seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        seen <= '0;
    else if (sec_tick) seen <= (seen == CNT_W'(DWELL_TICKS - 1)) ? '0 : seen + 1'b1;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_time_r1: assert (!page_is_date && dwell_cnt == '0)
        else $error("time page / zero count expected in clear");
    end
  end

  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_tick |=> $stable(page_is_date) && $stable(dwell_cnt));

  p_cnt_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dwell_cnt == seen);

  p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && seen == CNT_W'(DWELL_TICKS - 1)) |=> page_is_date != $past(page_is_date));

  p_wrap_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap_evt |=> $stable(page_is_date));

  p_blank_lanes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !page_is_date |-> disp_digits[7:0] == 8'hFF);

  p_time_lead_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !page_is_date |-> disp_digits[31:28] == hr_tens);

  p_date_lead_r4: assert property (@(posedge clk) disable iff (!rst_n)
    page_is_date |-> disp_digits[31:28] == yr_thou);

endmodule

bind cal_page_sel cal_page_sel_chk #(.DWELL_TICKS(DWELL_TICKS), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sec_tick     (sec_tick),
  .page_is_date (page_is_date),
  .disp_digits  (disp_digits),
  .dwell_cnt    (dwell_cnt),
  .wrap_evt     (wrap_evt),
  .yr_thou      (yr_thou),
  .hr_tens      (hr_tens)
);

// File: tb/cal_page_sel_tb.sv
module cal_page_sel_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0;
  logic [3:0] yr_thou, yr_hund, yr_tens, yr_unit, mon_tens, mon_unit, day_tens, day_unit;
  logic [3:0] hr_tens, hr_unit, min_tens, min_unit, sec_tens, sec_unit;
  logic [31:0] disp_digits;
  logic        page_is_date;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cal_page_sel u_dut (.*);

  // {date digits, time digits} = 14 BCD nibbles, expected date word, expected time word
  typedef struct packed {
    logic [55:0] digits;
    logic [31:0] exp_date;
    logic [31:0] exp_time;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{56'h20240229235958, 32'h20240229, 32'h235958FF},
    '{56'h19991231000000, 32'h19991231, 32'h000000FF},
    '{56'h20000101123456, 32'h20000101, 32'h123456FF},
    '{56'h21000715090807, 32'h21000715, 32'h090807FF}
  };

  task automatic apply(input logic [55:0] d);
    {yr_thou, yr_hund, yr_tens, yr_unit, mon_tens, mon_unit, day_tens, day_unit,
     hr_tens, hr_unit, min_tens, min_unit, sec_tens, sec_unit} = d;
  endtask

  task automatic chk32(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  // One tick per call; gap = idle cycles afterwards. Ends just after a negedge.
  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    apply(VECS[0].digits);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk1("R1 page in clear", page_is_date, 1'b0);
    chk32("R1 lanes in clear", disp_digits, VECS[0].exp_time);
    rst_n = 1'b1;
    @(negedge clk);
    chk1("R1 page after release", page_is_date, 1'b0);

    // Vector table: time page, 8 ticks -> date page, 8 more -> time page (R4 R5 R6 R8)
    foreach (VECS[v]) begin
      apply(VECS[v].digits);
      #1;
      chk32("R5 time lanes", disp_digits, VECS[v].exp_time);
      chk1("R6 time indicator", page_is_date, 1'b0);
      ticks(8, 0);
      chk32("R4 date lanes", disp_digits, VECS[v].exp_date);
      chk1("R6 date indicator", page_is_date, 1'b1);
      ticks(8, 1);
      chk32("R8 back to time", disp_digits, VECS[v].exp_time);
    end

    // R3: exact dwell length, R10 with sparse ticks
    ticks(7, 3);
    chk1("R3 no toggle after 7 ticks", page_is_date, 1'b0);
    ticks(1, 0);
    chk1("R3 toggle on 8th tick", page_is_date, 1'b1);

    // R2: long idle keeps page
    repeat (40) @(negedge clk);
    chk1("R2 idle hold", page_is_date, 1'b1);
    chk32("R2 idle lanes", disp_digits, VECS[3].exp_date);

    // R9: combinational follow on date page
    day_unit = 4'h8;
    #1;
    chk32("R9 date digit follow", disp_digits, 32'h21000718);

    // R8: 16 more ticks returns to date page
    ticks(16, 0);
    chk1("R8 date after 16 ticks", page_is_date, 1'b1);

    // R7: clear mid-dwell
    ticks(5, 0);
    rst_n = 1'b0;
    #1;
    chk1("R7 clear forces time page", page_is_date, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    ticks(7, 0);
    chk1("R7 full dwell after clear", page_is_date, 1'b0);
    ticks(1, 0);
    chk1("R7 toggle after 8 ticks", page_is_date, 1'b1);
    ticks(8, 0);

    // R9 on time page, R5 blank lanes
    sec_unit = 4'h1;
    #1;
    chk32("R9 time digit follow", disp_digits, 32'h090801FF);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule